// File: doc/BRIEF.md
# Watchdog Timer with Lockable Options Register

The block is a system watchdog. A free-running counter advances either on every bus clock cycle or only on the cycles where a slow reference tick is present. If software fails to service it before the counter reaches the selected terminal count, the block issues a one-cycle reset pulse. Software services the watchdog by writing any value to a dedicated service address.

The behaviour comes from three option bits held in an options register. The options register can be written only once after each reset. The first write fixes the enable, timeout length and count source. Every later write is ignored until the next external reset or the next watchdog pulse, which also puts the options back to their defaults. The terminal count is a power of two, and its exponent depends on both the count source and the length bit. The whole block runs on the bus clock, and the slow reference arrives as a single-cycle tick enable.

Top module: `wdg_core`

## Requirements
- R1: After reset the options register reads 0xC0 (bit 7 enable = 1, bit 6 long timeout = 1, bit 5 count source = 0, all other bits 0), and the reset output is low.
- R2: The first write to the options address after reset latches data bits 7, 6 and 5 as enable, long timeout and count source. A read of the options address returns those three bits in the same positions, with all other bits zero.
- R3: Once the options register has been written, further writes to the options address do not change it. This holds until an external reset or a watchdog pulse.
- R4: While the enable bit is 0, the reset output never goes high.
- R5: With count source 1, the counter advances on every bus clock cycle. The terminal count is 2^BUS_SHORT_LOG2 cycles when the long bit is 0 and 2^BUS_LONG_LOG2 cycles when it is 1.
- R6: With count source 0, the counter advances only on cycles where tick_i is high. The terminal count is 2^SLOW_SHORT_LOG2 ticks (32 by default) when the long bit is 0 and 2^SLOW_LONG_LOG2 ticks (256 by default) when it is 1.
- R7: A write of any data to the service address clears the counter. When a service write and a count event fall in the same cycle, the service write wins and the counter is cleared.
- R8: The reset output is a single-cycle pulse. It goes high in the cycle that follows the clock edge at which the N-th count event since the last service is taken, where N is the terminal count.
- R9: A watchdog pulse clears the counter, restores the options to 0xC0 and makes the options register writable again.
- R10: Reads of the service address, and of any address other than the options address, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow reference tick enable, one cycle wide |
| bus_sel_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wdata_i | input | DATA_W | Bus write data |
| bus_rdata_o | output | DATA_W | Bus read data, combinational |
| wdg_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bench builds the block with the bus-clock exponents lowered to 6 and 9. This brings both bus-clock timeouts, as well as the default 32- and 256-tick slow timeouts, within a short run, so all four terminal counts are measured exactly. Random option values, random tick spacing and random mid-run service writes are checked against a counting model. Directed cases cover the locked register, the disabled watchdog and the reopening of the lock after a pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CFG_EN_BIT   = 7;
  localparam int CFG_LONG_BIT = 6;
  localparam int CFG_BUS_BIT  = 5;

  typedef struct packed {
    logic en;
    logic long_to;
    logic bus_clk;
  } wdg_cfg_t;

  localparam wdg_cfg_t CFG_DEFAULT = '{en: 1'b1, long_to: 1'b1, bus_clk: 1'b0};
endpackage

// File: rtl/wdg_cfg_lock.sv
module wdg_cfg_lock
  import wdg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  wdg_cfg_t wdata_i,
  input  logic     clr_i,
  output wdg_cfg_t cfg_o,
  output logic     locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o    <= CFG_DEFAULT;
      locked_o <= 1'b0;
    end else if (clr_i) begin
      cfg_o    <= CFG_DEFAULT;
      locked_o <= 1'b0;
    end else if (wr_i && !locked_o) begin
      cfg_o    <= wdata_i;
      locked_o <= 1'b1;
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !clr_i) |=> $stable(cfg_o)); // R3
  AST_CLR_REOPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cfg_o == CFG_DEFAULT && !locked_o)); // R9
endmodule

// File: rtl/wdg_limit_sel.sv
module wdg_limit_sel #(
  parameter int SLOW_SHORT_LOG2 = 5,
  parameter int SLOW_LONG_LOG2  = 8,
  parameter int BUS_SHORT_LOG2  = 13,
  parameter int BUS_LONG_LOG2   = 18,
  parameter int CNT_W           = 18
) (
  input  logic             bus_clk_i,
  input  logic             long_i,
  output logic [CNT_W-1:0] lim_m1_o
);
  logic [CNT_W-1:0] tab [4];

  // index = {count source, long}
  for (genvar g = 0; g < 4; g++) begin : g_lim
    localparam int L = (g == 0) ? SLOW_SHORT_LOG2 :
                       (g == 1) ? SLOW_LONG_LOG2  :
                       (g == 2) ? BUS_SHORT_LOG2  : BUS_LONG_LOG2;
    assign tab[g] = CNT_W'((64'd1 << L) - 64'd1);
  end

  assign lim_m1_o = tab[{bus_clk_i, long_i}];
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             svc_i,
  input  logic [CNT_W-1:0] lim_m1_i,
  output logic             bite_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      bite_o <= 1'b0;
    end else if (bite_o) begin
      cnt_o  <= '0;
      bite_o <= 1'b0;
    end else if (svc_i || !en_i) begin
      cnt_o  <= '0;
    end else if (step_i) begin
      // >= keeps a shortened limit after a config change safe
      if (cnt_o >= lim_m1_i) begin
        cnt_o  <= '0;
        bite_o <= 1'b1;
      end else begin
        cnt_o <= cnt_o + CNT_W'(1);
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_o |=> !bite_o); // R8
  AST_SVC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && !bite_o) |=> (cnt_o == '0 && !bite_o)); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !bite_o); // R4
  AST_STEP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && !svc_i && !bite_o && cnt_o < lim_m1_i)
      |=> (cnt_o == $past(cnt_o) + CNT_W'(1))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !step_i && !svc_i && !bite_o) |=> $stable(cnt_o)); // R6
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int DATA_W          = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h03,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h00,
  parameter int SLOW_SHORT_LOG2 = 5,
  parameter int SLOW_LONG_LOG2  = 8,
  parameter int BUS_SHORT_LOG2  = 13,
  parameter int BUS_LONG_LOG2   = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              wdg_rst_o
);
  localparam int MAX_SLOW = (SLOW_LONG_LOG2 > SLOW_SHORT_LOG2) ? SLOW_LONG_LOG2 : SLOW_SHORT_LOG2;
  localparam int MAX_BUS  = (BUS_LONG_LOG2 > BUS_SHORT_LOG2) ? BUS_LONG_LOG2 : BUS_SHORT_LOG2;
  localparam int CNT_W    = (MAX_BUS > MAX_SLOW) ? MAX_BUS : MAX_SLOW;

  logic             cfg_wr, svc_wr, bite, locked;
  wdg_cfg_t         cfg_q, cfg_wdata;
  logic [CNT_W-1:0] lim_m1, cnt;
  logic             unused_sig;

  assign cfg_wr    = bus_sel_i && bus_we_i && (bus_addr_i == CFG_ADDR);
  assign svc_wr    = bus_sel_i && bus_we_i && (bus_addr_i == SVC_ADDR);
  assign cfg_wdata = '{en:      bus_wdata_i[CFG_EN_BIT],
                       long_to: bus_wdata_i[CFG_LONG_BIT],
                       bus_clk: bus_wdata_i[CFG_BUS_BIT]};
  assign unused_sig = ^{bus_wdata_i, locked, cnt};

  wdg_cfg_lock u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr),
    .wdata_i  (cfg_wdata),
    .clr_i    (bite),
    .cfg_o    (cfg_q),
    .locked_o (locked)
  );

  wdg_limit_sel #(
    .SLOW_SHORT_LOG2 (SLOW_SHORT_LOG2),
    .SLOW_LONG_LOG2  (SLOW_LONG_LOG2),
    .BUS_SHORT_LOG2  (BUS_SHORT_LOG2),
    .BUS_LONG_LOG2   (BUS_LONG_LOG2),
    .CNT_W           (CNT_W)
  ) u_lim (
    .bus_clk_i (cfg_q.bus_clk),
    .long_i    (cfg_q.long_to),
    .lim_m1_o  (lim_m1)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cfg_q.en),
    .step_i   (cfg_q.bus_clk | tick_i),
    .svc_i    (svc_wr),
    .lim_m1_i (lim_m1),
    .bite_o   (bite),
    .cnt_o    (cnt)
  );

  assign wdg_rst_o = bite;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == CFG_ADDR) begin
      bus_rdata_o[CFG_EN_BIT]   = cfg_q.en;
      bus_rdata_o[CFG_LONG_BIT] = cfg_q.long_to;
      bus_rdata_o[CFG_BUS_BIT]  = cfg_q.bus_clk;
    end
  end

  always_comb begin
    if (bus_addr_i != CFG_ADDR) begin
      AST_RDATA_ZERO: assert (bus_rdata_o == '0); // R10
    end
  end

  AST_NO_WRITE_WHILE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr && locked && !bite) |=> (bus_addr_i != CFG_ADDR || $stable(cfg_q))); // R3
endmodule

// File: tb/wdg_core_tb.sv
module wdg_core_tb;
  localparam logic [7:0] CFG_A = 8'h03;
  localparam logic [7:0] SVC_A = 8'h00;
  localparam int SS = 5, SL = 8, BS = 6, BL = 9;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       bite;

  int vectors = 0;
  int misses  = 0;

  always #4 clk = ~clk;

  wdg_core #(
    .ADDR_W(8), .DATA_W(8), .CFG_ADDR(CFG_A), .SVC_ADDR(SVC_A),
    .SLOW_SHORT_LOG2(SS), .SLOW_LONG_LOG2(SL),
    .BUS_SHORT_LOG2(BS), .BUS_LONG_LOG2(BL)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wdg_rst_o(bite)
  );

  function automatic int term(bit lng, bit bus);
    int e;
    e = bus ? (lng ? BL : BS) : (lng ? SL : SS);
    return 1 << e;
  endfunction

  function automatic logic [7:0] cfg_view(logic [7:0] v);
    return v & 8'hE0;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  // service, then count events until the pulse is seen; random extra services
  task automatic measure(bit bus, int n, output int events, output bit got);
    int svc_n;
    bus_write(SVC_A, 8'($urandom));
    events = 0; svc_n = 0; got = 1'b0;
    for (int it = 0; it < 6000; it++) begin
      if (bite) begin
        got = 1'b1;
        break;
      end
      tick = bus ? 1'b0 : (($urandom % 3) == 0);
      if (svc_n < 2 && events < n / 2 && ($urandom % 40) == 0) begin
        sel = 1'b1; we = 1'b1; addr = SVC_A; wdata = 8'($urandom);
        svc_n++;
        events = 0;   // R7: service beats a same-cycle tick
      end else begin
        sel = 1'b0; we = 1'b0;
        if (bus || tick) events++;
      end
      @(negedge clk);
    end
    sel = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    vectors++; misses++;
    $display("FAIL watchdog R1..R10 act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [7:0] r, v, v2;
    int ev, bites;
    bit got, lng, bus;
    void'($urandom(32'h5eed_1234));

    do_reset();
    check("R1 pulse low", int'(bite), 0);
    bus_read(CFG_A, r);
    check("R1 options default", int'(r), 8'hC0);
    bus_read(SVC_A, r);
    check("R10 service read", int'(r), 0);
    bus_read(8'h05, r);
    check("R10 unmapped read", int'(r), 0);

    bus_write(CFG_A, 8'hFF);
    bus_read(CFG_A, r);
    check("R2 first write", int'(r), 8'hE0);
    bus_write(CFG_A, 8'h00);
    bus_read(CFG_A, r);
    check("R3 second write ignored", int'(r), 8'hE0);

    // random configs: even iterations via external reset, odd via pulse reopening
    for (int k = 0; k < 8; k++) begin
      if (k % 2 == 0) do_reset();
      v = 8'($urandom) | 8'h80;
      lng = v[6]; bus = v[5];
      bus_write(CFG_A, v);
      bus_read(CFG_A, r);
      check((k % 2 == 0) ? "R2 latch" : "R9 reopened latch", int'(r), int'(cfg_view(v)));
      v2 = 8'($urandom);
      bus_write(CFG_A, v2);
      bus_read(CFG_A, r);
      check("R3 locked", int'(r), int'(cfg_view(v)));
      measure(bus, term(lng, bus), ev, got);
      check("R8 pulse seen", int'(got), 1);
      check(bus ? "R5 bus terminal count" : "R6 tick terminal count", ev, term(lng, bus));
      @(negedge clk);
      check("R8 single cycle", int'(bite), 0);
      bus_read(CFG_A, r);
      check("R9 defaults restored", int'(r), 8'hC0);
    end

    // default config without any options write: slow long
    do_reset();
    measure(1'b0, term(1'b1, 1'b0), ev, got);
    check("R6 default 256 ticks", ev, term(1'b1, 1'b0));

    // disabled watchdog with bus counting
    do_reset();
    bus_write(CFG_A, 8'h20);
    bites = 0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      tick = ($urandom % 2 == 0);
      if (bite) bites++;
    end
    tick = 1'b0;
    check("R4 disabled no pulse", bites, 0);
    bus_write(CFG_A, 8'hE0);
    bus_read(CFG_A, r);
    check("R3 enable write ignored", int'(r), 8'h20);
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (bite) bites++;
    end
    check("R4 still disabled", bites, 0);

    // continuous service keeps a short bus timeout from firing
    do_reset();
    bus_write(CFG_A, 8'hA0);
    bites = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      sel = 1'b1; we = 1'b1; addr = SVC_A; wdata = 8'($urandom);
      if (bite) bites++;
    end
    sel = 1'b0; we = 1'b0;
    check("R7 serviced no pulse", bites, 0);
    measure(1'b1, term(1'b0, 1'b1), ev, got);
    check("R5 short bus after service", ev, term(1'b0, 1'b1));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule